// File: doc/BRIEF.md
# Memory Operand Address Generator

This block turns the addressing fields of a decoded instruction into the location of its memory operand. The caller supplies a 2-bit mode field and a 3-bit register/memory field, the raw 16-bit displacement from the instruction, and the current contents of the two base registers (BX, BP), the two index registers (SI, DI) and the data segment register DS. The block adds the selected base, index and displacement into a 16-bit offset. It then places the offset in the data segment to form a 20-bit physical address.

Each request is a single-cycle strobe. One clock later the block presents the registered offset, the physical address and a register-operand flag, together with a one-cycle valid pulse. A register operand takes no memory access, so it produces no address. Between requests the outputs keep their last values. Segment-override prefixes and the memory access itself are handled elsewhere.

Top module: `ea_gen`

## Requirements
- R1: After reset, `out_valid`, `is_reg`, `offset` and `phys_addr` are all zero.
- R2: `out_valid` is high in exactly the cycle after each cycle in which `req_valid` is high, and low otherwise; back-to-back requests give back-to-back valid cycles.
- R3: With mode 2'b11 the operand is a register: `is_reg` is 1, and `offset` and `phys_addr` are 0. In every other mode `is_reg` is 0.
- R4: With mode 2'b00 and r/m 3'b110 the offset is the full 16-bit displacement input (direct addressing), and no register takes part.
- R5: With mode 2'b00 and any other r/m code, the offset is formed from registers alone and the displacement is ignored. The r/m codes map as follows: 000 BX+SI, 001 BX+DI, 010 BP+SI, 011 BP+DI, 100 SI, 101 DI, 111 BX.
- R6: With mode 2'b01 the offset is the register term from the R5 map, with r/m 110 meaning BP, plus the low displacement byte sign-extended to 16 bits. Displacement bits 15:8 are ignored.
- R7: With mode 2'b10 the offset is the register term from the R5 map, with r/m 110 meaning BP, plus the full 16-bit displacement.
- R8: All offset additions wrap modulo 2^16.
- R9: For a memory operand, `phys_addr` equals DS shifted left by 4 plus the offset, truncated to 20 bits.
- R10: In a cycle without a request, `offset`, `phys_addr` and `is_reg` keep their previous values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe; the fields below are sampled with it |
| mode_fld | input | 2 | Addressing mode field |
| rm_fld | input | 3 | Register/memory field |
| disp | input | 16 | Raw displacement or direct address |
| reg_bx | input | 16 | Base register BX |
| reg_bp | input | 16 | Base register BP |
| reg_si | input | 16 | Index register SI |
| reg_di | input | 16 | Index register DI |
| reg_ds | input | 16 | Data segment register |
| out_valid | output | 1 | One-cycle result strobe |
| is_reg | output | 1 | Operand is a register; no address |
| offset | output | 16 | Effective offset |
| phys_addr | output | 20 | Physical address |

## Verification
The hardest cases to reach are the ones where two wrap-arounds and an ignored field meet. In these, a negative byte displacement must pull a sum below zero or across 0xFFFF while the upper displacement byte holds garbage. A segment near 0xFFFF must also carry the physical sum past 20 bits. Random register values rarely hit these edges, so directed requests set them up explicitly: a base of 0x0000 with a displacement byte of 0x80, a full-scale three-term sum, and DS = 0xFFFF with offset 0xFFFF. Random requests over all mode and r/m codes then cover the rest of the map. Each is followed by a cycle of new random inputs with no request, to show that the outputs hold.

// File: rtl/ea_pkg.sv
`timescale 1ns/1ps
package ea_pkg;

  typedef enum logic [1:0] {
    BASE_NONE = 2'd0,
    BASE_BX   = 2'd1,
    BASE_BP   = 2'd2
  } base_sel_e;

  typedef enum logic [1:0] {
    IDX_NONE = 2'd0,
    IDX_SI   = 2'd1,
    IDX_DI   = 2'd2
  } idx_sel_e;

  typedef enum logic [1:0] {
    DSP_NONE = 2'd0,
    DSP_BYTE = 2'd1,
    DSP_WORD = 2'd2,
    DSP_ABS  = 2'd3
  } dsp_sel_e;

  typedef struct packed {
    base_sel_e base;
    idx_sel_e  idx;
    dsp_sel_e  dsp;
    logic      reg_op;
  } ea_ctl_t;

  localparam logic [1:0] MODE_NODISP = 2'b00;
  localparam logic [1:0] MODE_DISP8  = 2'b01;
  localparam logic [1:0] MODE_DISP16 = 2'b10;
  localparam logic [1:0] MODE_REG    = 2'b11;
  localparam logic [2:0] RM_DIRECT   = 3'b110;

endpackage

// File: rtl/ea_decode.sv
`timescale 1ns/1ps
module ea_decode
  import ea_pkg::*;
(
  input  logic [1:0] mode_fld,
  input  logic [2:0] rm_fld,
  output ea_ctl_t    ctl
);

  base_sel_e base_map;
  idx_sel_e  idx_map;

  // register combination selected by the r/m code
  always_comb begin
    base_map = BASE_NONE;
    idx_map  = IDX_NONE;
    unique case (rm_fld)
      3'b000: begin base_map = BASE_BX;   idx_map = IDX_SI;   end
      3'b001: begin base_map = BASE_BX;   idx_map = IDX_DI;   end
      3'b010: begin base_map = BASE_BP;   idx_map = IDX_SI;   end
      3'b011: begin base_map = BASE_BP;   idx_map = IDX_DI;   end
      3'b100: begin base_map = BASE_NONE; idx_map = IDX_SI;   end
      3'b101: begin base_map = BASE_NONE; idx_map = IDX_DI;   end
      3'b110: begin base_map = BASE_BP;   idx_map = IDX_NONE; end
      3'b111: begin base_map = BASE_BX;   idx_map = IDX_NONE; end
      default: begin base_map = BASE_NONE; idx_map = IDX_NONE; end
    endcase
  end

  // mode field picks the displacement kind and the special cases
  always_comb begin
    ctl.base   = base_map;
    ctl.idx    = idx_map;
    ctl.dsp    = DSP_NONE;
    ctl.reg_op = 1'b0;
    unique case (mode_fld)
      MODE_NODISP: begin
        if (rm_fld == RM_DIRECT) begin
          ctl.base = BASE_NONE;
          ctl.idx  = IDX_NONE;
          ctl.dsp  = DSP_ABS;
        end
      end
      MODE_DISP8:  ctl.dsp = DSP_BYTE;
      MODE_DISP16: ctl.dsp = DSP_WORD;
      MODE_REG: begin
        ctl.base   = BASE_NONE;
        ctl.idx    = IDX_NONE;
        ctl.reg_op = 1'b1;
      end
      default: ctl.dsp = DSP_NONE;
    endcase
  end

endmodule

// File: rtl/ea_sum.sv
`timescale 1ns/1ps
module ea_sum
  import ea_pkg::*;
#(
  parameter int AW      = 16,
  parameter int SHORT_W = 8
) (
  input  ea_ctl_t         ctl,
  input  logic [AW-1:0]   disp,
  input  logic [AW-1:0]   reg_bx,
  input  logic [AW-1:0]   reg_bp,
  input  logic [AW-1:0]   reg_si,
  input  logic [AW-1:0]   reg_di,
  output logic [AW-1:0]   sum
);

  localparam int EXT_W = AW - SHORT_W;

  logic [AW-1:0] base_v;
  logic [AW-1:0] idx_v;
  logic [AW-1:0] dsp_v;
  logic [AW-1:0] dsp_short;

  assign dsp_short = {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};

  always_comb begin
    unique case (ctl.base)
      BASE_BX: base_v = reg_bx;
      BASE_BP: base_v = reg_bp;
      default: base_v = '0;
    endcase
  end

  always_comb begin
    unique case (ctl.idx)
      IDX_SI:  idx_v = reg_si;
      IDX_DI:  idx_v = reg_di;
      default: idx_v = '0;
    endcase
  end

  always_comb begin
    unique case (ctl.dsp)
      DSP_BYTE: dsp_v = dsp_short;
      DSP_WORD: dsp_v = disp;
      DSP_ABS:  dsp_v = disp;
      default:  dsp_v = '0;
    endcase
  end

  // three-term sum, carries beyond AW bits are dropped
  assign sum = base_v + idx_v + dsp_v;

endmodule

// File: rtl/ea_phys.sv
`timescale 1ns/1ps
module ea_phys #(
  parameter int AW        = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PAW      = AW + SEG_SHIFT
) (
  input  logic [AW-1:0]  seg,
  input  logic [AW-1:0]  off,
  output logic [PAW-1:0] phys
);

  generate
    if (SEG_SHIFT > 0) begin : g_shift
      assign phys = {seg, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, off};
    end else begin : g_flat
      assign phys = seg + off;
    end
  endgenerate

endmodule

// File: rtl/ea_gen.sv
`timescale 1ns/1ps
module ea_gen
  import ea_pkg::*;
#(
  parameter int AW        = 16,
  parameter int SHORT_W   = 8,
  parameter int SEG_SHIFT = 4,
  parameter int SYNC_LEN  = 2,
  localparam int PAW      = AW + SEG_SHIFT
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [1:0]     mode_fld,
  input  logic [2:0]     rm_fld,
  input  logic [AW-1:0]  disp,
  input  logic [AW-1:0]  reg_bx,
  input  logic [AW-1:0]  reg_bp,
  input  logic [AW-1:0]  reg_si,
  input  logic [AW-1:0]  reg_di,
  input  logic [AW-1:0]  reg_ds,
  output logic           out_valid,
  output logic           is_reg,
  output logic [AW-1:0]  offset,
  output logic [PAW-1:0] phys_addr
);

  // reset: asserted asynchronously, released on a clock edge
  logic [SYNC_LEN-1:0] rst_pipe_q;
  logic                rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[SYNC_LEN-1];

  // datapath
  ea_ctl_t        ctl;
  logic [AW-1:0]  off_raw;
  logic [AW-1:0]  off_n;
  logic [PAW-1:0] phys_raw;
  logic [PAW-1:0] phys_n;

  ea_decode u_dec (
    .mode_fld (mode_fld),
    .rm_fld   (rm_fld),
    .ctl      (ctl)
  );

  ea_sum #(.AW(AW), .SHORT_W(SHORT_W)) u_sum (
    .ctl    (ctl),
    .disp   (disp),
    .reg_bx (reg_bx),
    .reg_bp (reg_bp),
    .reg_si (reg_si),
    .reg_di (reg_di),
    .sum    (off_raw)
  );

  ea_phys #(.AW(AW), .SEG_SHIFT(SEG_SHIFT)) u_phys (
    .seg  (reg_ds),
    .off  (off_raw),
    .phys (phys_raw)
  );

  // register operands produce no address
  assign off_n  = ctl.reg_op ? '0 : off_raw;
  assign phys_n = ctl.reg_op ? '0 : phys_raw;

  // next state
  logic           vld_d, vld_q;
  logic           reg_d, reg_q;
  logic [AW-1:0]  off_d, off_q;
  logic [PAW-1:0] phys_d, phys_q;
  logic           load_en;

  assign load_en = req_valid;

  always_comb begin
    vld_d  = req_valid;
    reg_d  = reg_q;
    off_d  = off_q;
    phys_d = phys_q;
    if (load_en) begin
      reg_d  = ctl.reg_op;
      off_d  = off_n;
      phys_d = phys_n;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      vld_q  <= 1'b0;
      reg_q  <= 1'b0;
      off_q  <= '0;
      phys_q <= '0;
    end else begin
      vld_q  <= vld_d;
      reg_q  <= reg_d;
      off_q  <= off_d;
      phys_q <= phys_d;
    end
  end

  assign out_valid = vld_q;
  assign is_reg    = reg_q;
  assign offset    = off_q;
  assign phys_addr = phys_q;

endmodule

// File: rtl/ea_gen_chk.sv
`timescale 1ns/1ps
module ea_gen_chk #(
  parameter int AW        = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PAW      = AW + SEG_SHIFT
) (
  input logic           clk,
  input logic           rst_core_n,
  input logic           req_valid,
  input logic [1:0]     mode_fld,
  input logic [2:0]     rm_fld,
  input logic [AW-1:0]  disp,
  input logic [AW-1:0]  reg_ds,
  input logic           out_valid,
  input logic           is_reg,
  input logic [AW-1:0]  offset,
  input logic [PAW-1:0] phys_addr
);

  logic [AW-1:0]  ds_seen_q;
  logic [PAW-1:0] phys_model;

  always_ff @(posedge clk) ds_seen_q <= reg_ds;
  assign phys_model = {ds_seen_q, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, offset};

  p_valid_after_req_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    req_valid |=> out_valid);

  p_no_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    !req_valid |=> !out_valid);

  p_reg_flag_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    req_valid |=> (is_reg == ($past(mode_fld) == 2'b11)));

  p_reg_no_addr_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (out_valid && is_reg) |-> (offset == '0 && phys_addr == '0));

  p_direct_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (req_valid && mode_fld == 2'b00 && rm_fld == 3'b110) |=> (offset == $past(disp)));

  p_phys_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (out_valid && !is_reg) |-> (phys_addr == phys_model));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    !req_valid |=> ($stable(offset) && $stable(phys_addr) && $stable(is_reg)));

endmodule

bind ea_gen ea_gen_chk #(.AW(AW), .SEG_SHIFT(SEG_SHIFT)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .req_valid  (req_valid),
  .mode_fld   (mode_fld),
  .rm_fld     (rm_fld),
  .disp       (disp),
  .reg_ds     (reg_ds),
  .out_valid  (out_valid),
  .is_reg     (is_reg),
  .offset     (offset),
  .phys_addr  (phys_addr)
);

// File: tb/ea_gen_test.sv
`timescale 1ns/1ps
module ea_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  mode_fld = '0;
  logic [2:0]  rm_fld = '0;
  logic [15:0] disp = '0, reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0, reg_ds = '0;
  logic        out_valid, is_reg;
  logic [15:0] offset;
  logic [19:0] phys_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ea_gen uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .mode_fld(mode_fld), .rm_fld(rm_fld), .disp(disp),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di), .reg_ds(reg_ds),
    .out_valid(out_valid), .is_reg(is_reg), .offset(offset), .phys_addr(phys_addr)
  );

  // spec model of the offset
  function automatic logic [15:0] exp_off(input logic [1:0] m, input logic [2:0] r,
                                          input logic [15:0] d, bx, bp, si, di);
    logic [15:0] t, dv;
    if (m == 2'b11) return 16'h0;
    if (m == 2'b00 && r == 3'b110) return d;
    case (r)
      3'd0: t = bx + si;
      3'd1: t = bx + di;
      3'd2: t = bp + si;
      3'd3: t = bp + di;
      3'd4: t = si;
      3'd5: t = di;
      3'd6: t = bp;
      default: t = bx;
    endcase
    dv = (m == 2'b01) ? {{8{d[7]}}, d[7:0]} : (m == 2'b10) ? d : 16'h0;
    return t + dv;
  endfunction

  function automatic logic [19:0] exp_phys(input logic [1:0] m, input logic [15:0] ds, off);
    logic [19:0] p;
    if (m == 2'b11) return 20'h0;
    p = {ds, 4'h0} + {4'h0, off};
    return p;
  endfunction

  function automatic string mode_tag(input logic [1:0] m, input logic [2:0] r);
    if (m == 2'b11) return "R3";
    if (m == 2'b00) return (r == 3'b110) ? "R4" : "R5";
    if (m == 2'b01) return "R6";
    return "R7";
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic set_fields(input logic [1:0] m, input logic [2:0] r, input logic [15:0] d,
                            bx, bp, si, di, ds);
    mode_fld = m; rm_fld = r; disp = d;
    reg_bx = bx; reg_bp = bp; reg_si = si; reg_di = di; reg_ds = ds;
  endtask

  // called at a negedge with fields already set for the request
  task automatic check_result(input logic [1:0] m, input logic [2:0] r, input logic [15:0] d,
                              bx, bp, si, di, ds, input string tag);
    logic [15:0] eo;
    eo = exp_off(m, r, d, bx, bp, si, di);
    chk("R2", "valid", {31'h0, out_valid}, 32'h1);
    chk("R3", "is_reg", {31'h0, is_reg}, {31'h0, (m == 2'b11)});
    chk(tag, "offset", {16'h0, offset}, {16'h0, eo});
    chk("R9", "phys", {12'h0, phys_addr}, {12'h0, exp_phys(m, ds, eo)});
  endtask

  task automatic one_req(input logic [1:0] m, input logic [2:0] r, input logic [15:0] d,
                         bx, bp, si, di, ds, input string tag);
    @(negedge clk);
    set_fields(m, r, d, bx, bp, si, di, ds);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_result(m, r, d, bx, bp, si, di, ds, tag);
  endtask

  // new inputs without a request: outputs must not move
  task automatic idle_hold;
    logic [15:0] o; logic [19:0] p; logic ir;
    o = offset; p = phys_addr; ir = is_reg;
    set_fields($urandom_range(3, 0), $urandom_range(7, 0), $urandom(), $urandom(), $urandom(),
               $urandom(), $urandom(), $urandom());
    @(negedge clk);
    chk("R2", "idle valid", {31'h0, out_valid}, 32'h0);
    chk("R10", "hold offset", {16'h0, offset}, {16'h0, o});
    chk("R10", "hold phys", {12'h0, phys_addr}, {12'h0, p});
    chk("R10", "hold is_reg", {31'h0, is_reg}, {31'h0, ir});
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset values
    chk("R1", "valid", {31'h0, out_valid}, 32'h0);
    chk("R1", "is_reg", {31'h0, is_reg}, 32'h0);
    chk("R1", "offset", {16'h0, offset}, 32'h0);
    chk("R1", "phys", {12'h0, phys_addr}, 32'h0);

    // R5: every register-only combination, displacement ignored
    for (int r = 0; r < 8; r++) begin
      if (r != 6)
        one_req(2'b00, r[2:0], 16'hBEEF, 16'h1000, 16'h2000, 16'h0030, 16'h0004, 16'h0100, "R5");
      idle_hold();
    end
    // R4: direct address
    one_req(2'b00, 3'b110, 16'h1234, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h2000, "R4");
    // R6: negative byte, garbage upper byte, wrap below zero (R8)
    one_req(2'b01, 3'b111, 16'hA580, 16'h0000, 16'h0, 16'h0, 16'h0, 16'h0000, "R6");
    one_req(2'b01, 3'b110, 16'h77FF, 16'h0, 16'h0010, 16'h0, 16'h0, 16'h0040, "R6");
    one_req(2'b01, 3'b000, 16'h007F, 16'h0100, 16'h0, 16'h0002, 16'h0, 16'h0000, "R6");
    // R7 and R8: full-scale three-term sum
    one_req(2'b10, 3'b000, 16'hFFFF, 16'hFFFF, 16'h0, 16'hFFFF, 16'h0, 16'h0001, "R8");
    one_req(2'b10, 3'b011, 16'h8000, 16'h0, 16'h8000, 16'h0, 16'h0001, 16'h1000, "R7");
    // R3: register operand
    one_req(2'b11, 3'b010, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555, 16'h6666, "R3");
    idle_hold();
    // R9: physical sum carries past 20 bits
    one_req(2'b00, 3'b110, 16'hFFFF, 16'h0, 16'h0, 16'h0, 16'h0, 16'hFFFF, "R9");

    // R2: back-to-back requests
    @(negedge clk);
    set_fields(2'b10, 3'b100, 16'h0010, 16'h0, 16'h0, 16'h0300, 16'h0, 16'h0050);
    req_valid = 1'b1;
    @(negedge clk);
    check_result(2'b10, 3'b100, 16'h0010, 16'h0, 16'h0, 16'h0300, 16'h0, 16'h0050, "R2");
    set_fields(2'b01, 3'b101, 16'h00F0, 16'h0, 16'h0, 16'h0, 16'h0100, 16'h0060);
    @(negedge clk);
    req_valid = 1'b0;
    check_result(2'b01, 3'b101, 16'h00F0, 16'h0, 16'h0, 16'h0, 16'h0100, 16'h0060, "R2");
    idle_hold();

    // random requests across all modes
    for (int i = 0; i < 400; i++) begin
      logic [1:0] m; logic [2:0] r;
      logic [15:0] d, bx, bp, si, di, ds;
      m = 2'($urandom_range(3, 0)); r = 3'($urandom_range(7, 0));
      d = 16'($urandom()); bx = 16'($urandom()); bp = 16'($urandom());
      si = 16'($urandom()); di = 16'($urandom()); ds = 16'($urandom());
      one_req(m, r, d, bx, bp, si, di, ds, mode_tag(m, r));
      if ((i % 4) == 0) idle_hold();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule